// File: doc/BRIEF.md
# Power-Rail Fault Response Sequencer

This block decides, for each output channel of a multi-rail regulator controller, whether the gate drive stays on, is cut for a timed retry, or is cut until someone steps in when a fault appears. Each channel has a 2-bit response code for faults it is told about, and a second code for its own start-up timeout. It raises a soft-start request each time it turns the rail on, and it keeps one sticky fault flag.

The start-up timeout counts in 10 µs steps. It runs only while the ramp generator reports that the turn-on delay has ended and the ramp is under way. If, when the count is used up, the output has not reached its undervoltage threshold or overcurrent is still present, the timeout fault fires. A free-running 1 µs tick input feeds two shared prescalers, one giving 10 µs ticks and one giving 1 ms ticks. The retry delay is counted in milliseconds.

Fault flags are cleared by a global clear pulse or by a rising edge on a channel's run input. A configuration input lets a rising edge on channel 0's run input clear the flags of every channel. All pins are plain control and status levels. The block has no data stream, so it has no valid/ready handshake.

Top module: `fault_resp_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, gate_en, ss_req and fault_flag are all low.
- R2: With run and on_cmd both high, a channel in the idle state raises gate_en and ss_req in the next cycle. While uv_ok is high and oc is low, ss_req falls in the next cycle and gate_en stays high.
- R3: If run or on_cmd is low in a cycle, gate_en and ss_req are low in the next cycle, whatever the channel state.
- R4: With response code 00 (ignore) for both faults and timeouts, a fault never lowers gate_en. It only sets fault_flag.
- R5: With response code 01 (retry), a fault while gate_en is high lowers gate_en in the next cycle. After the retry delay in ms has passed, a soft-start begins only if fault is low at that moment. Otherwise the channel waits one more full delay and checks again, and goes on doing so.
- R6: A retry delay below RETRY_MIN_MS (default 120) is treated as RETRY_MIN_MS.
- R7: With response code 10 or 11 (latch off), a fault while gate_en is high lowers gate_en in the next cycle. The gate stays off after the fault goes away, until enable (run and on_cmd) goes low and then high again.
- R8: fault_flag goes high in the cycle after fault is high or a timeout fires. A clear_all pulse makes it low in the next cycle in any state, and the clear wins over a fault in the same cycle.
- R9: A rising edge on a channel's run input clears that channel's fault_flag in the next cycle. With share_clr high, a rising edge on channel 0's run input clears the fault_flag of every channel. With share_clr low, other channels keep their flags.
- R10: In soft-start, the timeout counter advances one step per 10 µs tick, and only while ss_begin is high. When ton_max steps have elapsed without the output being good, the timeout fault fires and is handled by to_mode. Code 00 moves the channel to the running state with the gate on.
- R11: The output counts as good only when uv_ok is high and oc is low. Overcurrent that persists keeps the channel in soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | 1 µs timebase pulse |
| clear_all | input | 1 | Clear every fault flag |
| share_clr | input | 1 | Channel 0 run edge clears all channels |
| run | input | NCH | Per-channel run level |
| on_cmd | input | NCH | Per-channel on/off command |
| fault | input | NCH | Fault present |
| uv_ok | input | NCH | Output above undervoltage threshold |
| oc | input | NCH | Overcurrent present |
| ss_begin | input | NCH | Turn-on delay done, ramp under way |
| flt_mode | input | 2*NCH | Fault response code per channel |
| to_mode | input | 2*NCH | Timeout response code per channel |
| retry_ms | input | RW*NCH | Retry delay in ms per channel |
| ton_max | input | TW*NCH | Start-up timeout in 10 µs steps |
| gate_en | output | NCH | Gate-drive enable |
| ss_req | output | NCH | Soft-start request |
| fault_flag | output | NCH | Sticky fault flag |

## Verification
Randomised sequences of fault pulses and clear pulses in ignore mode are compared against a flag model each cycle. They separate a set-wins flag from a clear-wins flag, and they show whether the gate is ever dropped. Directed retry runs use a single-cycle fault, a fault held across one expiry, and a delay below the minimum. They tell apart a fixed restart, a restart that checks the fault, and a delay that is clamped. Latch, timeout and run-edge cases use both response codes for latch off, both settings of share_clr, and ss_begin high and low. These cases tell apart the exit paths and the clear scope.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_START,
    ST_RUN,
    ST_HICCUP,
    ST_LATCH
  } chan_st_e;

  localparam logic [1:0] MODE_IGNORE = 2'b00;
  localparam logic [1:0] MODE_RETRY  = 2'b01;

  // state taken when a non-ignored fault hits a powered channel
  function automatic chan_st_e fault_exit(input logic [1:0] mode);
    return (mode == MODE_RETRY) ? ST_HICCUP : ST_LATCH;
  endfunction
endpackage

// File: rtl/frs_tick_div.sv
module frs_tick_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_out
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (tick_in)
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_out = tick_in && (cnt_q == LAST);

  // R10: prescaler count never leaves its range
  a_r10_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/frs_chan.sv
module frs_chan
  import frs_pkg::*;
#(
  parameter int RW = 17,
  parameter int TW = 16,
  parameter int RETRY_MIN_MS = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick10,
  input  logic          tick_ms,
  input  logic          clr,
  input  logic          run,
  input  logic          on_cmd,
  input  logic          fault,
  input  logic          uv_ok,
  input  logic          oc,
  input  logic          ss_begin,
  input  logic [1:0]    flt_mode,
  input  logic [1:0]    to_mode,
  input  logic [RW-1:0] retry_ms,
  input  logic [TW-1:0] ton_max,
  output logic          gate_en,
  output logic          ss_req,
  output logic          fault_flag
);
  localparam logic [RW-1:0] DLY_MIN = RW'(RETRY_MIN_MS);

  chan_st_e      st_q, st_d;
  logic [TW-1:0] tmr_q;
  logic [RW-1:0] rcnt_q;
  logic [RW-1:0] dly_eff;
  logic          en, good, to_hit, dly_last;

  assign en       = run && on_cmd;
  assign good     = uv_ok && !oc;
  assign dly_eff  = (retry_ms < DLY_MIN) ? DLY_MIN : retry_ms;
  assign dly_last = ((RW+1)'(rcnt_q) + 1'b1) >= (RW+1)'(dly_eff);
  assign to_hit   = (st_q == ST_START) && ss_begin && !good && tick10 &&
                    (((TW+1)'(tmr_q) + 1'b1) >= (TW+1)'(ton_max));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:   st_d = ST_START;
      ST_START: begin
        if (fault && flt_mode != MODE_IGNORE) st_d = fault_exit(flt_mode);
        else if (good)                        st_d = ST_RUN;
        else if (to_hit)
          st_d = (to_mode == MODE_IGNORE) ? ST_RUN : fault_exit(to_mode);
      end
      ST_RUN: begin
        if (fault && flt_mode != MODE_IGNORE) st_d = fault_exit(flt_mode);
      end
      ST_HICCUP: begin
        if (tick_ms && dly_last && !fault) st_d = ST_START;
      end
      ST_LATCH: st_d = ST_LATCH;
      default:  st_d = ST_OFF;
    endcase
    if (!en) st_d = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      tmr_q      <= '0;
      rcnt_q     <= '0;
      fault_flag <= 1'b0;
    end else begin
      st_q <= st_d;

      if (st_q != ST_START)        tmr_q <= '0;
      else if (ss_begin && tick10) tmr_q <= tmr_q + 1'b1;

      if (st_q != ST_HICCUP) rcnt_q <= '0;
      else if (tick_ms)      rcnt_q <= dly_last ? '0 : rcnt_q + 1'b1;

      if (clr)                  fault_flag <= 1'b0;
      else if (fault || to_hit) fault_flag <= 1'b1;
    end
  end

  assign gate_en = (st_q == ST_START) || (st_q == ST_RUN);
  assign ss_req  = (st_q == ST_START);

  // R3: dropping enable removes the gate drive next cycle
  a_r3_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && on_cmd) |=> !gate_en);
  // R7: latch-off code cuts the gate at once
  a_r7_latch_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && fault && flt_mode[1]) |=> !gate_en);
  // R4: ignore codes never remove the gate while enabled
  a_r4_ignore_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && run && on_cmd && flt_mode == MODE_IGNORE &&
     to_mode == MODE_IGNORE) |=> gate_en);
  // R5: a restart out of hiccup happens only with the fault gone
  a_r5_retry_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_req && $past(st_q == ST_HICCUP)) |-> !$past(fault));
  // R8: a clear always wins
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fault_flag);
endmodule

// File: rtl/fault_resp_seq.sv
module fault_resp_seq #(
  parameter int NCH          = 2,
  parameter int RW           = 17,
  parameter int TW           = 16,
  parameter int TEN_DIV      = 10,
  parameter int MS_DIV       = 1000,
  parameter int RETRY_MIN_MS = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              clear_all,
  input  logic              share_clr,
  input  logic [NCH-1:0]    run,
  input  logic [NCH-1:0]    on_cmd,
  input  logic [NCH-1:0]    fault,
  input  logic [NCH-1:0]    uv_ok,
  input  logic [NCH-1:0]    oc,
  input  logic [NCH-1:0]    ss_begin,
  input  logic [2*NCH-1:0]  flt_mode,
  input  logic [2*NCH-1:0]  to_mode,
  input  logic [RW*NCH-1:0] retry_ms,
  input  logic [TW*NCH-1:0] ton_max,
  output logic [NCH-1:0]    gate_en,
  output logic [NCH-1:0]    ss_req,
  output logic [NCH-1:0]    fault_flag
);
  localparam int US_PER_MS_DIV = MS_DIV;

  logic           tick10, tick_ms;
  logic [NCH-1:0] run_q, run_rise, clr;

  frs_tick_div #(.DIV(TEN_DIV)) u_div10 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_us), .tick_out(tick10)
  );
  frs_tick_div #(.DIV(US_PER_MS_DIV)) u_divms (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_us), .tick_out(tick_ms)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run;
  end

  assign run_rise = run & ~run_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign clr[i] = clear_all || run_rise[i] || (share_clr && run_rise[0]);

    frs_chan #(.RW(RW), .TW(TW), .RETRY_MIN_MS(RETRY_MIN_MS)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick10    (tick10),
      .tick_ms   (tick_ms),
      .clr       (clr[i]),
      .run       (run[i]),
      .on_cmd    (on_cmd[i]),
      .fault     (fault[i]),
      .uv_ok     (uv_ok[i]),
      .oc        (oc[i]),
      .ss_begin  (ss_begin[i]),
      .flt_mode  (flt_mode[2*i +: 2]),
      .to_mode   (to_mode[2*i +: 2]),
      .retry_ms  (retry_ms[RW*i +: RW]),
      .ton_max   (ton_max[TW*i +: TW]),
      .gate_en   (gate_en[i]),
      .ss_req    (ss_req[i]),
      .fault_flag(fault_flag[i])
    );
  end

  // R9: a run edge on channel 0 with sharing on clears every flag
  a_r9_shared_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (share_clr && run[0] && !run_q[0]) |=> (fault_flag == '0));
endmodule

// File: tb/fault_resp_seq_bench.sv
module fault_resp_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int RW = 17;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic clear_all = 1'b0;
  logic share_clr = 1'b0;
  logic [NCH-1:0] run = '0, on_cmd = '0, fault = '0, uv_ok = '0, oc = '0, ss_begin = '0;
  logic [2*NCH-1:0] flt_mode = '0, to_mode = '0;
  logic [RW*NCH-1:0] retry_ms = '0;
  logic [TW*NCH-1:0] ton_max = '0;
  logic [NCH-1:0] gate_en, ss_req, fault_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_resp_seq #(.NCH(NCH), .RW(RW), .TW(TW), .TEN_DIV(2), .MS_DIV(4),
                   .RETRY_MIN_MS(120)) u_fault_resp_seq (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .clear_all(clear_all),
    .share_clr(share_clr), .run(run), .on_cmd(on_cmd), .fault(fault),
    .uv_ok(uv_ok), .oc(oc), .ss_begin(ss_begin), .flt_mode(flt_mode),
    .to_mode(to_mode), .retry_ms(retry_ms), .ton_max(ton_max),
    .gate_en(gate_en), .ss_req(ss_req), .fault_flag(fault_flag)
  );

  function automatic bit flag_model(bit prev, bit f, bit c);
    return c ? 1'b0 : (prev | f);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clear_all = 1'b1; step(1); clear_all = 1'b0;
  endtask

  task automatic recycle0();
    on_cmd[0] = 1'b0; step(1); on_cmd[0] = 1'b1; step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit exp_flag;
    void'($urandom(32'd4242));
    retry_ms[16:0] = 17'd120;
    ton_max[15:0]  = 16'd10;
    step(3);
    chk("R1 gate_en in reset", gate_en, 0);
    chk("R1 fault_flag in reset", fault_flag, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 ss_req after reset", ss_req, 0);

    // R2 start, R10 no timeout while ss_begin low, R11 oc holds soft-start
    run[0] = 1'b1; on_cmd[0] = 1'b1;
    step(1);
    chk("R2 gate_en on start", gate_en[0], 1);
    chk("R2 ss_req on start", ss_req[0], 1);
    step(50);
    chk("R10 no timeout without ss_begin", fault_flag[0], 0);
    uv_ok[0] = 1'b1; oc[0] = 1'b1;
    step(5);
    chk("R11 oc keeps soft-start", ss_req[0], 1);
    oc[0] = 1'b0;
    step(1);
    chk("R2 ss_req falls when good", ss_req[0], 0);
    chk("R2 gate stays on", gate_en[0], 1);

    // R4 ignore, R8 flag behaviour
    fault[0] = 1'b1; step(1);
    chk("R4 gate kept on fault", gate_en[0], 1);
    chk("R8 flag set by fault", fault_flag[0], 1);
    fault[0] = 1'b0; step(3);
    chk("R4 gate still on", gate_en[0], 1);
    pulse_clear();
    chk("R8 clear_all clears", fault_flag[0], 0);
    fault[0] = 1'b1; clear_all = 1'b1; step(1);
    chk("R8 clear wins over fault", fault_flag[0], 0);
    clear_all = 1'b0; step(1);
    chk("R8 fault sets again", fault_flag[0], 1);
    fault[0] = 1'b0; pulse_clear();

    // constrained random ignore-mode run against the flag model (R4, R8)
    exp_flag = 1'b0;
    for (int i = 0; i < 300; i++) begin
      fault[0]  = ($urandom % 4) == 0;
      clear_all = ($urandom % 8) == 0;
      step(1);
      exp_flag = flag_model(exp_flag, fault[0], clear_all);
      chk("R8 random flag", fault_flag[0], exp_flag);
      chk("R4 random gate", gate_en[0], 1);
    end
    fault[0] = 1'b0; clear_all = 1'b0;
    pulse_clear();

    // R3 command off
    on_cmd[0] = 1'b0; step(1);
    chk("R3 gate off on cmd low", gate_en[0], 0);
    chk("R3 ss_req off on cmd low", ss_req[0], 0);
    on_cmd[0] = 1'b1; step(2);
    chk("R3 restart after cmd high", gate_en[0], 1);

    // R5 retry with a one-cycle fault
    flt_mode[1:0] = 2'b01;
    fault[0] = 1'b1; step(1); fault[0] = 1'b0;
    chk("R5 gate cut on fault", gate_en[0], 0);
    step(469);
    chk("R5 still off before delay", gate_en[0], 0);
    step(15);
    chk("R5 restart after delay", gate_en[0], 1);

    // R5 fault held across the first expiry
    fault[0] = 1'b1; step(1);
    chk("R5 gate cut again", gate_en[0], 0);
    step(484);
    chk("R5 no restart with fault present", gate_en[0], 0);
    fault[0] = 1'b0;
    step(454);
    chk("R5 waits a second full delay", gate_en[0], 0);
    step(35);
    chk("R5 restart after second delay", gate_en[0], 1);

    // R6 clamp of a short retry delay
    retry_ms[16:0] = 17'd5;
    fault[0] = 1'b1; step(1); fault[0] = 1'b0;
    step(399);
    chk("R6 short delay clamped", gate_en[0], 0);
    step(85);
    chk("R6 restart at minimum delay", gate_en[0], 1);

    // R7 latch off, code 10 then 11
    flt_mode[1:0] = 2'b10;
    fault[0] = 1'b1; step(1); fault[0] = 1'b0;
    chk("R7 latch cuts gate", gate_en[0], 0);
    step(600);
    chk("R7 stays latched", gate_en[0], 0);
    recycle0();
    chk("R7 off-on restarts", gate_en[0], 1);
    step(2);
    flt_mode[1:0] = 2'b11;
    fault[0] = 1'b1; step(1); fault[0] = 1'b0;
    chk("R7 code 11 latches", gate_en[0], 0);
    step(10);
    chk("R7 code 11 stays off", gate_en[0], 0);

    // R10 timeout with latch code
    flt_mode[1:0] = 2'b00; to_mode[1:0] = 2'b10;
    uv_ok[0] = 1'b0; ss_begin[0] = 1'b1;
    on_cmd[0] = 1'b0; step(1); pulse_clear();
    on_cmd[0] = 1'b1; step(1);
    step(14);
    chk("R10 no early timeout", fault_flag[0], 0);
    chk("R10 still in soft-start", ss_req[0], 1);
    step(10);
    chk("R10 timeout flag", fault_flag[0], 1);
    chk("R10 timeout latches gate", gate_en[0], 0);

    // R10 timeout with ignore code
    to_mode[1:0] = 2'b00;
    on_cmd[0] = 1'b0; step(1); pulse_clear();
    on_cmd[0] = 1'b1; step(25);
    chk("R10 ignore timeout keeps gate", gate_en[0], 1);
    chk("R10 ignore timeout leaves soft-start", ss_req[0], 0);
    chk("R10 ignore timeout flag", fault_flag[0], 1);

    // R9 run-edge clearing
    fault[1] = 1'b1; step(1); fault[1] = 1'b0;
    chk("R8 channel 1 flag set", fault_flag[1], 1);
    share_clr = 1'b0;
    run[0] = 1'b0; step(1); run[0] = 1'b1; step(1);
    chk("R9 own flag cleared", fault_flag[0], 0);
    chk("R9 no share keeps other flag", fault_flag[1], 1);
    share_clr = 1'b1;
    run[0] = 1'b0; step(1); run[0] = 1'b1; step(1);
    chk("R9 shared clear", fault_flag[1], 0);
    share_clr = 1'b0;
    fault[1] = 1'b1; step(1); fault[1] = 1'b0;
    run[1] = 1'b1; step(1);
    chk("R9 channel 1 own edge", fault_flag[1], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule